// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches 32 already-synchronized GPIO pin levels and turns selected transitions into interrupts. Every pin carries two independent enables, one for rising transitions and one for falling transitions; turning on both makes the pin interrupt on either edge, and turning off both silences it. Each enable mask is changed only through a pair of write ports: one sets the bits written as one, the other clears them. Nothing else in the mask changes, so software needs no read-modify-write.

A detected edge latches into a 32-bit pending register. Software clears pending bits by writing ones, which usually means writing back the value it just read. The pins are split into two banks of 16. Bank 0 owns pending bits 15:0 and bank 1 owns bits 31:16. Each bank drives one level-type interrupt line. That line is high while its bank enable is on and any pending bit in its half is set. The bank enable register is five bits wide. Only the two lowest bits gate a line; the other three are stored and read back.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset every readable register is zero: both enable masks, the pending register and the bank enable. Both interrupt lines are low.
- R2: Writing to address 1 sets the rising-enable bits that are one in the write data. Writing to address 2 clears them. Other bits keep their value. The mask reads back at address 0.
- R3: Writing to address 4 sets the falling-enable bits that are one in the write data. Writing to address 5 clears them. Other bits keep their value. The mask reads back at address 3.
- R4: A pin whose level goes 0→1 while its rising enable is set has its pending bit set at the next clock edge. A 0→1 change with the rising enable clear leaves the pending bit unchanged.
- R5: A pin whose level goes 1→0 while its falling enable is set has its pending bit set at the next clock edge. A 1→0 change with the falling enable clear leaves the pending bit unchanged.
- R6: A pin with both enables set latches a pending bit on a rising change and again on a falling change.
- R7: The pending register reads at address 6. A write to address 6 clears each pending bit written as one and leaves bits written as zero unchanged.
- R8: Suppose a clear write and a newly detected edge hit the same pending bit in one cycle. The edge wins and the bit stays set.
- R9: Interrupt line bit 0 is high exactly when bank enable bit 0 is set and any of pending bits 15:0 is set. Line bit 1 follows the same rule with bank enable bit 1 and pending bits 31:16.
- R10: The bank enable register is written and read at address 7, and its low five bits are stored. Clearing a bank enable drops that line but leaves the pending bits intact.
- R11: Address 8 reads the current synchronized pin levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| bank_irq | output | 2 | Per-bank level interrupt lines |

## Verification
The assertions assume the pin inputs are already synchronous to clk and hold steady between clock edges. The stimulus changes pins, addresses and write data only on falling clock edges. The assertions also assume that software is the only thing that clears pending bits. An enabled line that drops therefore implies a clear write in the cycle before. The bench never turns a bank enable off in the same cycle that it clears pending bits, so that rule stays unambiguous.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_RISE_EN  = 4'd0,
    A_RISE_SET = 4'd1,
    A_RISE_CLR = 4'd2,
    A_FALL_EN  = 4'd3,
    A_FALL_SET = 4'd4,
    A_FALL_CLR = 4'd5,
    A_PENDING  = 4'd6,
    A_BANK_EN  = 4'd7,
    A_LEVEL    = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  function automatic logic [N-1:0] up_edges(input logic [N-1:0] cur, input logic [N-1:0] old);
    return cur & ~old;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = up_edges(lvl, prev_q);
  assign fall = up_edges(prev_q, lvl);
endmodule

// File: rtl/gpio_pending_reg.sv
module gpio_pending_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  function automatic logic [N-1:0] next_pend(input logic [N-1:0] cur, input logic [N-1:0] c,
                                             input logic [N-1:0] h);
    return (cur & ~c) | h;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= next_pend(pend, clr, hit);
  end

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend & $past(hit)) == $past(hit))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hit) != '0) |=> ((pend & $past(clr & ~hit)) == '0)); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R4
endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate #(
  parameter int unsigned N      = 32,
  parameter int unsigned BANK_W = 16,
  parameter int unsigned EN_W   = 5,
  localparam int unsigned NB    = N / BANK_W
) (
  input  logic [N-1:0]    pend,
  input  logic [EN_W-1:0] bank_en,
  output logic [NB-1:0]   irq
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign irq[b] = bank_en[b] & (|pend[b*BANK_W +: BANK_W]);
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_W   = 16,
  parameter int unsigned BEN_W    = 5,
  localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_lvl,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NUM_PINS-1:0]   bus_wdata,
  output logic [NUM_PINS-1:0]   bus_rdata,
  output logic [NUM_BANKS-1:0]  bank_irq
);
  logic [NUM_PINS-1:0] rise_en_q, fall_en_q;
  logic [BEN_W-1:0]    bank_en_q;
  logic [NUM_PINS-1:0] rise_ev, fall_ev, edge_hit, pend_clr, pend_q;
  logic                wr_pend;

  function automatic logic [NUM_PINS-1:0] set_clr(input logic [NUM_PINS-1:0] cur,
      input logic do_set, input logic do_clr, input logic [NUM_PINS-1:0] m);
    logic [NUM_PINS-1:0] r;
    r = cur;
    if (do_set) r = r | m;
    if (do_clr) r = r & ~m;
    return r;
  endfunction

  gpio_edge_detect #(.N(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .rise(rise_ev), .fall(fall_ev));

  assign edge_hit = (rise_ev & rise_en_q) | (fall_ev & fall_en_q);
  assign wr_pend  = bus_wr && (bus_addr == A_PENDING);
  assign pend_clr = wr_pend ? bus_wdata : '0;

  gpio_pending_reg #(.N(NUM_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .hit(edge_hit), .clr(pend_clr), .pend(pend_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      bank_en_q <= '0;
    end else begin
      rise_en_q <= set_clr(rise_en_q, bus_wr && bus_addr == A_RISE_SET,
                           bus_wr && bus_addr == A_RISE_CLR, bus_wdata);
      fall_en_q <= set_clr(fall_en_q, bus_wr && bus_addr == A_FALL_SET,
                           bus_wr && bus_addr == A_FALL_CLR, bus_wdata);
      if (bus_wr && bus_addr == A_BANK_EN) bank_en_q <= bus_wdata[BEN_W-1:0];
    end
  end

  gpio_bank_gate #(.N(NUM_PINS), .BANK_W(BANK_W), .EN_W(BEN_W)) u_gate (
    .pend(pend_q), .bank_en(bank_en_q), .irq(bank_irq));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RISE_EN: bus_rdata = rise_en_q;
      A_FALL_EN: bus_rdata = fall_en_q;
      A_PENDING: bus_rdata = pend_q;
      A_BANK_EN: bus_rdata[BEN_W-1:0] = bank_en_q;
      A_LEVEL:   bus_rdata = pin_lvl;
      default:   bus_rdata = '0;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_IRQ_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bank_irq[b]) && bank_en_q[b] && $past(bank_en_q[b])) |-> $past(wr_pend)); // R9
  end
  AST_ENABLE_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RISE_SET) |=> ((rise_en_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_lvl = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  bank_irq;

  always #2 clk = ~clk;

  gpio_edge_irq u0 (.clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_irq(bank_irq));

  typedef struct { logic [31:0] rd; logic [1:0] irq; string tag; } exp_t;
  exp_t sb[$];
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  logic [31:0] m_ren = '0, m_fen = '0, m_pend = '0, m_prev = '0, m_pins = '0;
  logic [4:0]  m_ben = '0;

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_ren;
      4'd3: return m_fen;
      4'd6: return m_pend;
      4'd7: return {27'd0, m_ben};
      4'd8: return m_pins;
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] model_irq();
    return {m_ben[1] & (|m_pend[31:16]), m_ben[0] & (|m_pend[15:0])};
  endfunction

  task automatic step(input logic [31:0] p, input logic w, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] hit;
    @(negedge clk);
    pin_lvl = p; bus_wr = w; bus_addr = a; bus_wdata = d;
    hit = ((p & ~m_prev) & m_ren) | ((~p & m_prev) & m_fen);
    m_prev = p; m_pins = p;
    m_pend = (m_pend & ~((w && a == 4'd6) ? d : 32'd0)) | hit;
    if (w) begin
      case (a)
        4'd1: m_ren = m_ren | d;
        4'd2: m_ren = m_ren & ~d;
        4'd4: m_fen = m_fen | d;
        4'd5: m_fen = m_fen & ~d;
        4'd7: m_ben = d[4:0];
        default: ;
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(m_pins, 1'b1, a, d);
  endtask

  task automatic pins(input logic [31:0] p);
    step(p, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic expect_rd(input logic [3:0] a, input string tag);
    exp_t e;
    bus_addr = a;
    e.rd = model_rd(a); e.irq = model_irq(); e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        e = sb.pop_front();
        n_cmp++;
        if (bus_rdata !== e.rd || bank_irq !== e.irq) begin
          n_bad++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", e.tag, bus_rdata, bank_irq, e.rd, e.irq);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 9; a++) expect_rd(a[3:0], "R1 reset");

    wr(4'd1, 32'h0001_00F1); expect_rd(4'd0, "R2 rise set");
    wr(4'd2, 32'h0000_0030); expect_rd(4'd0, "R2 rise clr");
    wr(4'd4, 32'h8000_0F02); expect_rd(4'd3, "R3 fall set");
    wr(4'd5, 32'h0000_0300); expect_rd(4'd3, "R3 fall clr");
    wr(4'd7, 32'h0000_001F); expect_rd(4'd7, "R10 bank en");

    pins(32'h0000_0001); expect_rd(4'd6, "R4 rise enabled");
    pins(32'h0000_0009); expect_rd(4'd6, "R4 rise disabled pin3");
    expect_rd(4'd8, "R11 level");
    pins(32'h0000_0808); expect_rd(4'd6, "R5 set pin11 high");
    pins(32'h0000_0000); expect_rd(4'd6, "R5 fall pin11 and none pin0");

    wr(4'd6, 32'h0000_0001); expect_rd(4'd6, "R7 w1c partial");
    expect_rd(4'd0, "R9 irq bank0 still");
    wr(4'd6, 32'hFFFF_FFFF); expect_rd(4'd6, "R7 clear all");

    wr(4'd1, 32'h0000_0100); wr(4'd4, 32'h0000_0100);
    pins(32'h0000_0100); expect_rd(4'd6, "R6 both rise");
    wr(4'd6, 32'h0000_0100); expect_rd(4'd6, "R6 cleared");
    pins(32'h0000_0000); expect_rd(4'd6, "R6 both fall");

    wr(4'd6, 32'hFFFF_FFFF);
    step(32'h0000_0001, 1'b1, 4'd6, 32'h0000_0101); expect_rd(4'd6, "R8 edge beats clear");

    pins(32'h8001_0001); expect_rd(4'd6, "R9 bank1 rise");
    pins(32'h0001_0001); expect_rd(4'd6, "R9 bank1 fall pin31");
    wr(4'd7, 32'h0000_0001); expect_rd(4'd6, "R10 gate off bank1 keeps pending");
    wr(4'd7, 32'h0000_0000); expect_rd(4'd7, "R10 gate all off");
    wr(4'd7, 32'h0000_0002); expect_rd(4'd6, "R9 bank1 only");
    wr(4'd6, 32'hFFFF_0000); expect_rd(4'd6, "R9 bank1 cleared");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule